// File: doc/BRIEF.md
# Audio Frame Sequencer with Frame Interrupt

This block paces the slow clocks of a retro console sound unit. One tick of its clock is one half-rate step. A frame position counter advances once per tick. At fixed positions it emits a quarter-frame pulse, which clocks envelopes and linear counters, and a half-frame pulse, which clocks length counters. Two frame layouts are supported: a four-event frame of 29830 ticks and a longer five-event frame of 37282 ticks.

Software picks the layout and an interrupt-inhibit option with a control write. The new layout does not take hold at once. A short alignment sequence waits for an odd tick and then restarts the frame from position zero. If the long layout is chosen and no strobe has occurred in the last two ticks, the restart also issues an immediate half-frame pulse.

In the four-event layout, the block raises a frame interrupt flag near the end of every frame. The flag stays set until an acknowledge pulse or a status read-clear pulse. The channel counters that use the pulses are outside this block.

Top module: `frame_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both pulses and the interrupt flag are 0. The block starts in the four-event layout with the interrupt enabled. The alignment sequence starts as though a write had just occurred, so the first frame restarts from position 0 at the third tick edge after reset.
- R2: The frame position runs from 0 up to 29829 in the four-event layout, or up to 37281 in the five-event layout, and then wraps to 0.
- R3: A quarter pulse is produced at positions 7457, 14913 and 22371 in both layouts. A further quarter pulse comes at 29829 in the four-event layout only, and at 37281 in the five-event layout only.
- R4: A half pulse is produced together with the quarter pulse at position 14913 and at the last position of the active layout. No other positional half pulse exists.
- R5: A pulse from position P is a single-cycle output that is high during the cycle after the tick in which the position equals P. The frame restarts at position 0 with the tick that follows the apply tick.
- R6: A write with `wr_five_step`=1 selects the five-event layout, and with 0 it selects the four-event layout. Writing `wr_irq_inhibit`=1 clears a pending interrupt in the cycle after the write and blocks new ones. Writing it as 0 allows them again.
- R7: The raw tick parity toggles every tick and restarts at even when a layout is applied. After a write, one tick moves to waiting. The first later tick with odd parity moves to ready. The next tick applies: the position and parity are reset, the new layout takes effect, and no positional event or interrupt is raised in that tick. The apply therefore lands 3 or 4 ticks after the write.
- R8: Every strobe event loads a suppression count of 2, which then counts down once per tick. When applying the five-event layout while the count is 0, a half pulse (without a quarter pulse) is produced in the cycle after the apply tick. While the count is nonzero, that pulse is suppressed.
- R9: In the four-event layout with interrupts allowed, the flag is set at positions 29828 and 29829. It is also set at position 0, except on the tick right after an apply or after reset.
- R10: An acknowledge or read-clear pulse clears the flag in the following cycle, and clearing takes priority over a set in the same tick.
- R11: The five-event layout never sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| wr_en | input | 1 | Control write strobe, one cycle |
| wr_five_step | input | 1 | Layout select with the write: 1 = five-event, 0 = four-event |
| wr_irq_inhibit | input | 1 | Interrupt inhibit with the write: 1 = clear and block the flag |
| irq_ack | input | 1 | Acknowledge pulse that clears the flag |
| stat_rd | input | 1 | Status read pulse that clears the flag |
| qtr_pulse | output | 1 | Quarter-frame pulse |
| half_pulse | output | 1 | Half-frame pulse |
| frame_irq | output | 1 | Frame interrupt flag |

## Verification
The bench tracks the apply tick of each frame on its own. After a write, the apply falls 3 or 4 ticks later, depending on the parity that the bench derives from the tick count since the last apply. A positional pulse for position P is then due exactly P+2 cycles after that apply edge, and an interrupt set at position P shows on the flag in the same cycle. A clear, an inhibit write or an immediate half pulse appears one cycle after its stimulus edge. Each check samples on the falling clock edge of the exact cycle it targets, and most checks are paired with the cycle before or after, so an off-by-one timing error is reported rather than hidden.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;

  typedef enum logic {
    STEP4 = 1'b0,
    STEP5 = 1'b1
  } step_mode_e;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_INIT  = 2'd1,
    HS_WAIT  = 2'd2,
    HS_READY = 2'd3
  } hs_state_e;

endpackage

// File: rtl/fseq_align.sv
`timescale 1ns/1ps
module fseq_align
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_five_step,
  input  logic       wr_irq_inhibit,
  input  logic       odd_tick,
  output logic       apply,
  output step_mode_e cur_mode,
  output step_mode_e next_mode,
  output logic       inhibit,
  output logic       inh_clr
);

  hs_state_e  state_q, state_d;
  step_mode_e pend_q, pend_d;
  step_mode_e mode_q, mode_d;
  logic       inh_q, inh_d;

  // alignment sequence; a fresh write always restarts it
  always_comb begin
    state_d = state_q;
    apply   = 1'b0;
    if (wr_en) begin
      state_d = HS_INIT;
    end else begin
      unique case (state_q)
        HS_INIT:  state_d = HS_WAIT;
        HS_WAIT:  if (odd_tick) state_d = HS_READY;
        HS_READY: begin
          state_d = HS_IDLE;
          apply   = 1'b1;
        end
        default:  state_d = HS_IDLE;
      endcase
    end
  end

  always_comb begin
    pend_d  = pend_q;
    inh_d   = inh_q;
    mode_d  = mode_q;
    inh_clr = wr_en & wr_irq_inhibit;
    if (wr_en) begin
      pend_d = wr_five_step ? STEP5 : STEP4;
      inh_d  = wr_irq_inhibit;
    end
    if (apply) begin
      mode_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_INIT;
      pend_q  <= STEP4;
      mode_q  <= STEP4;
      inh_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      mode_q  <= mode_d;
      inh_q   <= inh_d;
    end
  end

  assign cur_mode  = mode_q;
  assign next_mode = pend_q;
  assign inhibit   = inh_q;

  // R7: ready is only entered from an odd tick, so parity has flipped to even
  p_ready_after_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_READY) |-> !odd_tick);

  // R6: a write is reflected in the pending layout on the next cycle
  p_write_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (next_mode == $past(wr_five_step ? STEP5 : STEP4)) && (inhibit == $past(wr_irq_inhibit)));

endmodule

// File: rtl/fseq_position.sv
`timescale 1ns/1ps
module fseq_position
  import fseq_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int END4  = 29829,
  parameter int END5  = 37281
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  step_mode_e       cur_mode,
  output logic [POS_W-1:0] pos,
  output logic             odd_tick,
  output logic             fresh
);

  localparam logic [POS_W-1:0] LAST4 = POS_W'(END4);
  localparam logic [POS_W-1:0] LAST5 = POS_W'(END5);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             par_q, par_d;
  logic             fresh_q, fresh_d;
  logic [POS_W-1:0] last;

  always_comb begin
    last    = (cur_mode == STEP5) ? LAST5 : LAST4;
    fresh_d = apply;
    if (apply) begin
      pos_d = '0;
      par_d = 1'b0;
    end else begin
      pos_d = (pos_q == last) ? '0 : pos_q + POS_W'(1);
      par_d = ~par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      par_q   <= 1'b0;
      fresh_q <= 1'b1;
    end else begin
      pos_q   <= pos_d;
      par_q   <= par_d;
      fresh_q <= fresh_d;
    end
  end

  assign pos      = pos_q;
  assign odd_tick = par_q;
  assign fresh    = fresh_q;

  // R2: position stays inside the active frame
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == STEP4) |-> (pos <= LAST4));

  // R7: apply restarts position and parity
  p_apply_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (pos == '0) && !odd_tick && fresh);

endmodule

// File: rtl/fseq_strobe.sv
`timescale 1ns/1ps
module fseq_strobe
  import fseq_pkg::*;
#(
  parameter int POS_W     = 16,
  parameter int Q1        = 7457,
  parameter int Q2        = 14913,
  parameter int Q3        = 22371,
  parameter int END4      = 29829,
  parameter int END5      = 37281,
  parameter int SUPP_W    = 2,
  parameter int SUPP_LOAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  input  step_mode_e       cur_mode,
  input  logic             apply,
  input  step_mode_e       next_mode,
  output logic             qtr_pulse,
  output logic             half_pulse
);

  localparam logic [POS_W-1:0]  P_Q1   = POS_W'(Q1);
  localparam logic [POS_W-1:0]  P_Q2   = POS_W'(Q2);
  localparam logic [POS_W-1:0]  P_Q3   = POS_W'(Q3);
  localparam logic [POS_W-1:0]  P_E4   = POS_W'(END4);
  localparam logic [POS_W-1:0]  P_E5   = POS_W'(END5);
  localparam logic [SUPP_W-1:0] S_LOAD = SUPP_W'(SUPP_LOAD);

  logic              end_hit, mid_hit, q_hit, h_hit, imm_half;
  logic              qtr_q, half_q;
  logic [SUPP_W-1:0] supp_q, supp_d;

  always_comb begin
    end_hit  = ((cur_mode == STEP4) && (pos == P_E4)) ||
               ((cur_mode == STEP5) && (pos == P_E5));
    mid_hit  = (pos == P_Q1) || (pos == P_Q2) || (pos == P_Q3);
    // the apply tick discards the old position, so nothing decodes there
    q_hit    = !apply && (mid_hit || end_hit);
    h_hit    = !apply && ((pos == P_Q2) || end_hit);
    imm_half = apply && (next_mode == STEP5) && (supp_q == '0);
    if (q_hit || imm_half) begin
      supp_d = S_LOAD;
    end else if (supp_q != '0) begin
      supp_d = supp_q - SUPP_W'(1);
    end else begin
      supp_d = supp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
      supp_q <= '0;
    end else begin
      qtr_q  <= q_hit;
      half_q <= h_hit || imm_half;
      supp_q <= supp_d;
    end
  end

  assign qtr_pulse  = qtr_q;
  assign half_pulse = half_q;

  // R5: quarter pulses last one cycle
  p_qtr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_pulse |=> !qtr_pulse);

  // R4: a positional half pulse always comes with a quarter pulse
  p_half_with_qtr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_pulse && !$past(apply)) |-> qtr_pulse);

  // R8: an apply inside the suppression window gives no half pulse
  p_imm_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && (supp_q != '0)) |=> !half_pulse);

endmodule

// File: rtl/fseq_irq.sv
`timescale 1ns/1ps
module fseq_irq
  import fseq_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int END4  = 29829
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  input  step_mode_e       cur_mode,
  input  logic             inhibit,
  input  logic             fresh,
  input  logic             apply,
  input  logic             irq_ack,
  input  logic             stat_rd,
  input  logic             inh_clr,
  output logic             frame_irq
);

  localparam logic [POS_W-1:0] P_LAST = POS_W'(END4);
  localparam logic [POS_W-1:0] P_PREV = POS_W'(END4 - 1);

  logic flag_q, flag_d;
  logic set_hit, clr_hit;

  always_comb begin
    set_hit = !apply && (cur_mode == STEP4) && !inhibit &&
              ((pos == P_PREV) || (pos == P_LAST) || ((pos == '0) && !fresh));
    clr_hit = irq_ack || stat_rd || inh_clr;
    flag_d  = clr_hit ? 1'b0 : (flag_q || set_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign frame_irq = flag_q;

  // R10: any clear source wins in the following cycle
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || stat_rd || inh_clr) |=> !frame_irq);

  // R11 and R9: the flag only rises in the four-event layout with interrupts allowed
  p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> (cur_mode == STEP4) && !inhibit);

endmodule

// File: rtl/frame_sequencer.sv
`timescale 1ns/1ps
module frame_sequencer
  import fseq_pkg::*;
#(
  parameter int POS_W     = 16,
  parameter int Q1        = 7457,
  parameter int Q2        = 14913,
  parameter int Q3        = 22371,
  parameter int END4      = 29829,
  parameter int END5      = 37281,
  parameter int SUPP_W    = 2,
  parameter int SUPP_LOAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_five_step,
  input  logic wr_irq_inhibit,
  input  logic irq_ack,
  input  logic stat_rd,
  output logic qtr_pulse,
  output logic half_pulse,
  output logic frame_irq
);

  logic             apply;
  step_mode_e       cur_mode;
  step_mode_e       next_mode;
  logic             inhibit;
  logic             inh_clr;
  logic [POS_W-1:0] pos;
  logic             odd_tick;
  logic             fresh;

  fseq_align u_align (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_five_step   (wr_five_step),
    .wr_irq_inhibit (wr_irq_inhibit),
    .odd_tick       (odd_tick),
    .apply          (apply),
    .cur_mode       (cur_mode),
    .next_mode      (next_mode),
    .inhibit        (inhibit),
    .inh_clr        (inh_clr)
  );

  fseq_position #(
    .POS_W (POS_W),
    .END4  (END4),
    .END5  (END5)
  ) u_position (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (apply),
    .cur_mode (cur_mode),
    .pos      (pos),
    .odd_tick (odd_tick),
    .fresh    (fresh)
  );

  fseq_strobe #(
    .POS_W     (POS_W),
    .Q1        (Q1),
    .Q2        (Q2),
    .Q3        (Q3),
    .END4      (END4),
    .END5      (END5),
    .SUPP_W    (SUPP_W),
    .SUPP_LOAD (SUPP_LOAD)
  ) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos        (pos),
    .cur_mode   (cur_mode),
    .apply      (apply),
    .next_mode  (next_mode),
    .qtr_pulse  (qtr_pulse),
    .half_pulse (half_pulse)
  );

  fseq_irq #(
    .POS_W (POS_W),
    .END4  (END4)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos       (pos),
    .cur_mode  (cur_mode),
    .inhibit   (inhibit),
    .fresh     (fresh),
    .apply     (apply),
    .irq_ack   (irq_ack),
    .stat_rd   (stat_rd),
    .inh_clr   (inh_clr),
    .frame_irq (frame_irq)
  );

  // R1: outputs stay quiet on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !qtr_pulse && !half_pulse && !frame_irq);

endmodule

// File: tb/tb_frame_sequencer.sv
`timescale 1ns/1ps
module tb_frame_sequencer;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_five_step, wr_irq_inhibit, irq_ack, stat_rd;
  logic qtr_pulse, half_pulse, frame_irq;

  int cyc;
  int total = 0;
  int bad = 0;
  int a_edge;

  always #5 clk = ~clk;

  frame_sequencer dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_five_step   (wr_five_step),
    .wr_irq_inhibit (wr_irq_inhibit),
    .irq_ack        (irq_ack),
    .stat_rd        (stat_rd),
    .qtr_pulse      (qtr_pulse),
    .half_pulse     (half_pulse),
    .frame_irq      (frame_irq)
  );

  // edge index e moves cyc to e+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at cyc %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic expect_at(int n, string req, int q, int h, int irq);
    wait_to(n);
    chk(req, "qtr", int'(qtr_pulse), q);
    chk(req, "half", int'(half_pulse), h);
    chk(req, "irq", int'(frame_irq), irq);
  endtask

  // parity after edge e is (e - apply edge) mod 2, per R7
  function automatic int apply_edge_of(int w, int a);
    return (((w + 1 - a) % 2) == 1) ? w + 3 : w + 4;
  endfunction

  // drive at the negedge where cyc==W so that edge W takes the write
  task automatic do_write(logic five, logic inh);
    wr_en = 1'b1; wr_five_step = five; wr_irq_inhibit = inh;
    @(negedge clk);
    wr_en = 1'b0; wr_five_step = 1'b0; wr_irq_inhibit = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "qtr in reset", int'(qtr_pulse), 0);
    chk("R1", "irq in reset", int'(frame_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    a_edge = 2;
    expect_at(1, "R1", 0, 0, 0);
    expect_at(3, "R1", 0, 0, 0);
    expect_at(4, "R9", 0, 0, 0);
  endtask

  task automatic t_four_sched;
    expect_at(a_edge + 7458, "R5", 0, 0, 0);
    expect_at(a_edge + 7459, "R3", 1, 0, 0);
    expect_at(a_edge + 7460, "R5", 0, 0, 0);
    expect_at(a_edge + 14915, "R4", 1, 1, 0);
    expect_at(a_edge + 22373, "R3", 1, 0, 0);
  endtask

  task automatic t_irq_read;
    expect_at(29831, "R9", 0, 0, 0);
    expect_at(29832, "R9", 0, 0, 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R10", "irq clear beats set", int'(frame_irq), 0);
    chk("R3", "qtr at end4", int'(qtr_pulse), 1);
    chk("R4", "half at end4", int'(half_pulse), 1);
    expect_at(29834, "R9", 0, 0, 1);
    wait_to(29840);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R10", "irq after read", int'(frame_irq), 0);
    expect_at(29850, "R10", 0, 0, 0);
  endtask

  task automatic t_irq_ack;
    expect_at(59661, "R2", 0, 0, 0);
    expect_at(59662, "R2", 0, 0, 1);
    wait_to(59670);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R10", "irq after ack", int'(frame_irq), 0);
  endtask

  task automatic t_suppress;
    int w;
    w = 67118;
    wait_to(w);
    do_write(1'b1, 1'b0);
    a_edge = apply_edge_of(w, a_edge);
    chk("R7", "apply edge", a_edge, 67121);
    expect_at(67121, "R3", 1, 0, 0);
    expect_at(67122, "R8", 0, 0, 0);
  endtask

  task automatic t_immediate;
    int w;
    w = a_edge + 100;
    wait_to(w);
    do_write(1'b1, 1'b0);
    a_edge = apply_edge_of(w, a_edge);
    expect_at(a_edge, "R7", 0, 0, 0);
    expect_at(a_edge + 1, "R8", 0, 1, 0);
    expect_at(a_edge + 2, "R8", 0, 0, 0);
  endtask

  task automatic t_five_sched;
    expect_at(a_edge + 7459, "R7", 1, 0, 0);
    expect_at(a_edge + 14915, "R4", 1, 1, 0);
    expect_at(a_edge + 22373, "R3", 1, 0, 0);
    expect_at(a_edge + 29830, "R11", 0, 0, 0);
    expect_at(a_edge + 29831, "R3", 0, 0, 0);
    expect_at(a_edge + 37283, "R4", 1, 1, 0);
    expect_at(a_edge + 37284, "R11", 0, 0, 0);
    expect_at(a_edge + 37282 + 7459, "R2", 1, 0, 0);
  endtask

  task automatic t_inhibit;
    int w;
    int e;
    w = a_edge + 37282 + 7470;
    wait_to(w);
    do_write(1'b0, 1'b0);
    a_edge = apply_edge_of(w, a_edge);
    expect_at(a_edge + 29829, "R6", 0, 0, 0);
    expect_at(a_edge + 29830, "R6", 0, 0, 1);
    e = a_edge + 29840;
    wait_to(e);
    do_write(1'b0, 1'b1);
    chk("R6", "inhibit clears irq", int'(frame_irq), 0);
    a_edge = apply_edge_of(e, a_edge);
    expect_at(a_edge + 29830, "R6", 0, 0, 0);
    expect_at(a_edge + 29831, "R6", 1, 1, 0);
    expect_at(a_edge + 29832, "R6", 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_five_step = 1'b0; wr_irq_inhibit = 1'b0;
    irq_ack = 1'b0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    t_four_sched;
    t_irq_read;
    t_irq_ack;
    t_suppress;
    t_immediate;
    t_five_sched;
    t_inhibit;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (198000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule